// File: doc/BRIEF.md
# Interrupt-Pending Register with Merged External Line

This block holds the machine-level interrupt-pending register of a small processor core. It carries out CSR accesses against a 32-bit pending vector. A 2-bit operation code selects the access kind: plain write, bit-set or bit-clear. A read enable and a write enable gate the access. Read data is combinational and returns the value held before the access. Updates land on the next rising clock edge.

Supervisor external-interrupt pending, bit 9, has two sources. One is a software-writable latch. The other is a live level from an external interrupt controller. Reads and the pending vector to the priority logic both show the OR of the two. Every read-modify-write works only on the latch, so the external level is never captured into state. This lets higher-privilege software inject a supervisor external interrupt without hiding or swallowing a real one.

Machine software, timer and external pending bits are read-only copies of their input lines. Supervisor software and timer pending are plain writable flops. All other positions are constant zero.

Top module: `irq_pend_csr`

## Requirements
- R1: After reset, with all interrupt lines low, every bit of the pending vector and of the read data is zero.
- R2: Bit 9 of both the read data and pend_o equals the software latch OR s_ext_irq_i. A high external line raises bit 9 even while the latch is zero.
- R3: Bit-set (csr_op_i = 2'b01) returns latch|external at bit 9. After the edge, the latch holds its old value OR csr_wdata_i[9].
- R4: Plain write (csr_op_i = 2'b00) returns latch|external at bit 9. After the edge, the latch holds csr_wdata_i[9], whatever the external line is.
- R5: Bit-clear (csr_op_i = 2'b10) returns latch|external at bit 9. After the edge, the latch holds its old value AND NOT csr_wdata_i[9].
- R6: No operation ever loads the external line into the latch. After any access made while s_ext_irq_i is high, bit 9 reads zero once the line falls, unless the operand itself set the latch.
- R7: Bit-set or bit-clear with an all-zero operand performs no write, and code 2'b11 never writes. The latch and the writable bits keep their values.
- R8: Bits 3, 7 and 11 always equal m_sw_irq_i, m_timer_irq_i and m_ext_irq_i. Writes to these bits have no effect.
- R9: Bits 1 and 5 are software-writable flops that follow the same write, set and clear rules as the bit-9 latch.
- R10: Every bit other than 1, 3, 5, 7, 9 and 11 reads zero and ignores writes.
- R11: csr_rdata_o is zero while csr_re_i is low. A write changes state only at the rising edge after the access, and only when csr_we_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_op_i | input | 2 | 00 write, 01 set, 10 clear, 11 no write |
| csr_we_i | input | 1 | Write enable for the access |
| csr_re_i | input | 1 | Read enable for the access |
| csr_wdata_i | input | 32 | Write operand (register or immediate) |
| csr_rdata_o | output | 32 | Value before the access |
| m_sw_irq_i | input | 1 | Machine software interrupt line |
| m_timer_irq_i | input | 1 | Machine timer interrupt line |
| m_ext_irq_i | input | 1 | Machine external interrupt line |
| s_ext_irq_i | input | 1 | Supervisor external interrupt level from the controller |
| pend_o | output | 32 | Merged pending vector to the priority stage |

## Verification
The assertions check, on every cycle, the following properties:
- the OR-merge at bit 9 on both the read path and pend_o;
- the read-only mirroring of the machine lines and the zeroes in unimplemented positions;
- that the writable state stays put without a write;
- that set never clears the latch and clear never sets it.

The claim that the latch never absorbs the external level, with the zero-operand and no-write cases, shows only through the bench's scenarios. In those, the line is dropped after an access and the next read reveals what was stored.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_SET   = 2'b01,
    OP_CLEAR = 2'b10,
    OP_NONE  = 2'b11
  } csr_op_e;

  localparam int unsigned S_SW_BIT  = 1;
  localparam int unsigned M_SW_BIT  = 3;
  localparam int unsigned S_TMR_BIT = 5;
  localparam int unsigned M_TMR_BIT = 7;
  localparam int unsigned S_EXT_BIT = 9;
  localparam int unsigned M_EXT_BIT = 11;
endpackage

// File: rtl/irq_pend_alu.sv
module irq_pend_alu
  import irq_pend_pkg::*;
#(
  parameter int unsigned        W       = 32,
  parameter logic [W-1:0]       WR_MASK = '0
) (
  input  csr_op_e       op_i,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  old_i,
  output logic [W-1:0]  new_o,
  output logic          wr_o
);
  logic [W-1:0] opnd;
  logic         opnd_zero;

  assign opnd      = wdata_i & WR_MASK;
  assign opnd_zero = (wdata_i == '0);

  always_comb begin
    new_o = old_i;
    wr_o  = 1'b0;
    unique case (op_i)
      OP_WRITE: begin new_o = opnd;           wr_o = we_i; end
      OP_SET:   begin new_o = old_i | opnd;   wr_o = we_i && !opnd_zero; end
      OP_CLEAR: begin new_o = old_i & ~opnd;  wr_o = we_i && !opnd_zero; end
      default:  begin new_o = old_i;          wr_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/irq_pend_regs.sv
module irq_pend_regs #(
  parameter int unsigned  W       = 32,
  parameter logic [W-1:0] WR_MASK = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [W-1:0]  d_i,
  output logic [W-1:0]  q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (WR_MASK[b]) begin : g_ff
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= 1'b0;
        else if (en_i) q <= d_i[b];
      end
      assign q_o[b] = q;
    end else begin : g_zero
      assign q_o[b] = 1'b0;
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/irq_pend_csr.sv
module irq_pend_csr
  import irq_pend_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    csr_op_i,
  input  logic          csr_we_i,
  input  logic          csr_re_i,
  input  logic [W-1:0]  csr_wdata_i,
  output logic [W-1:0]  csr_rdata_o,
  input  logic          m_sw_irq_i,
  input  logic          m_timer_irq_i,
  input  logic          m_ext_irq_i,
  input  logic          s_ext_irq_i,
  output logic [W-1:0]  pend_o
);
  localparam logic [W-1:0] WR_MASK = (W'(1) << S_SW_BIT) | (W'(1) << S_TMR_BIT)
                                   | (W'(1) << S_EXT_BIT);
  localparam logic [W-1:0] RO_MASK = (W'(1) << M_SW_BIT) | (W'(1) << M_TMR_BIT)
                                   | (W'(1) << M_EXT_BIT);
  localparam logic [W-1:0] IMPL    = WR_MASK | RO_MASK;

  csr_op_e      op;
  logic [W-1:0] sw_q, sw_d, hw_v, merged;
  logic         wr;

  assign op = csr_op_e'(csr_op_i);

  irq_pend_alu #(.W(W), .WR_MASK(WR_MASK)) i_alu (
    .op_i    (op),
    .we_i    (csr_we_i),
    .wdata_i (csr_wdata_i),
    .old_i   (sw_q),
    .new_o   (sw_d),
    .wr_o    (wr)
  );

  irq_pend_regs #(.W(W), .WR_MASK(WR_MASK)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (wr),
    .d_i    (sw_d),
    .q_o    (sw_q)
  );

  // hardware-sourced bits; external supervisor level only ORed, never stored
  always_comb begin
    hw_v            = '0;
    hw_v[M_SW_BIT]  = m_sw_irq_i;
    hw_v[M_TMR_BIT] = m_timer_irq_i;
    hw_v[M_EXT_BIT] = m_ext_irq_i;
    hw_v[S_EXT_BIT] = s_ext_irq_i;
  end

  assign merged      = sw_q | hw_v;
  assign pend_o      = merged;
  assign csr_rdata_o = csr_re_i ? merged : '0;

  // R2
  ext_merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o[S_EXT_BIT] == (sw_q[S_EXT_BIT] | s_ext_irq_i));
  // R8
  ro_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o[M_TMR_BIT] == m_timer_irq_i && pend_o[M_EXT_BIT] == m_ext_irq_i
    && pend_o[M_SW_BIT] == m_sw_irq_i);
  // R10
  unimpl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & ~IMPL) == '0);
  // R3
  set_no_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && op == OP_SET && sw_q[S_EXT_BIT]) |=> sw_q[S_EXT_BIT]);
  // R5
  clr_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && op == OP_CLEAR && !sw_q[S_EXT_BIT]) |=> !sw_q[S_EXT_BIT]);
  // R11
  rd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_re_i |-> csr_rdata_o == '0);
endmodule

// File: tb/test_irq_pend_csr.sv
module test_irq_pend_csr;
  localparam logic [31:0] WMASK = 32'h0000_0222;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op = 2'b11;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd, pend;
  logic        msw = 0, mt = 0, me = 0, se = 0;

  int checks = 0, errors = 0;
  logic [31:0] model = '0;

  always #10 clk = ~clk;

  irq_pend_csr i_irq_pend_csr (
    .clk_i(clk), .rst_ni(rst_n), .csr_op_i(op), .csr_we_i(we), .csr_re_i(re),
    .csr_wdata_i(wd), .csr_rdata_o(rd), .m_sw_irq_i(msw), .m_timer_irq_i(mt),
    .m_ext_irq_i(me), .s_ext_irq_i(se), .pend_o(pend)
  );

  function automatic logic [31:0] exp_view(logic [31:0] sw, logic a, logic b,
                                           logic c, logic d);
    return sw | (32'(a) << 3) | (32'(b) << 7) | (32'(c) << 11) | (32'(d) << 9);
  endfunction

  function automatic logic [31:0] exp_next(logic [31:0] old, logic [1:0] o,
                                           logic w, logic [31:0] d);
    if (!w) return old;
    case (o)
      2'b00: return d & WMASK;
      2'b01: return (d == 0) ? old : (old | (d & WMASK));
      2'b10: return (d == 0) ? old : (old & ~(d & WMASK));
      default: return old;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, logic [1:0] o, logic w, logic r, logic [31:0] d,
                     logic a, logic b, logic c, logic e);
    logic [31:0] v;
    @(negedge clk);
    op = o; we = w; re = r; wd = d; msw = a; mt = b; me = c; se = e;
    #1;
    v = exp_view(model, a, b, c, e);
    check({tag, " pend"}, pend, v);
    check({tag, " rdata"}, rd, r ? v : 32'h0);
    model = exp_next(model, o, w, d);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #25 rst_n = 1'b1;
    // R1 reset state
    cyc("R1", 2'b11, 0, 1, 0, 0, 0, 0, 0);
    // R2 external alone raises bit 9
    cyc("R2", 2'b11, 0, 1, 0, 0, 0, 0, 1);
    // R7 set with zero operand while external high: no capture
    cyc("R7", 2'b01, 1, 1, 32'h0, 0, 0, 0, 1);
    // R6 line drops; latch must still be zero
    cyc("R6", 2'b11, 0, 1, 0, 0, 0, 0, 0);
    // R3 set bit 9 via operand
    cyc("R3", 2'b01, 1, 1, 32'h200, 0, 0, 0, 0);
    cyc("R3 after", 2'b11, 0, 1, 0, 0, 0, 0, 0);
    // R5 clear with external high, old read is merged
    cyc("R5", 2'b10, 1, 1, 32'h200, 0, 0, 0, 1);
    cyc("R5 after", 2'b11, 0, 1, 0, 0, 0, 0, 0);
    // R9 R10 write all ones
    cyc("R9 R10", 2'b00, 1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    cyc("R9 R10 after", 2'b11, 0, 1, 0, 0, 0, 0, 0);
    // R7 clear with zero operand keeps bits
    cyc("R7 clr0", 2'b10, 1, 1, 32'h0, 0, 0, 0, 0);
    // R4 write zero while external high
    cyc("R4", 2'b00, 1, 1, 32'h0, 0, 0, 0, 1);
    cyc("R4 after", 2'b11, 0, 1, 0, 0, 0, 0, 0);
    // R8 machine lines mirrored, writes ignored
    cyc("R8", 2'b00, 1, 1, 32'h0000_0888, 1, 1, 1, 0);
    cyc("R8 after", 2'b11, 0, 1, 0, 0, 0, 0, 0);
    // R11 read gating and next-edge update
    cyc("R11 re0", 2'b00, 1, 0, 32'h200, 0, 0, 0, 0);
    cyc("R11 edge", 2'b00, 0, 1, 32'h0, 0, 0, 0, 0);
    cyc("R11 we0", 2'b11, 0, 1, 0, 0, 0, 0, 0);
    // R6 random traffic including R3 R4 R5 R9 operations
    for (int i = 0; i < 600; i++) begin
      logic [31:0] d;
      d = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      cyc("R6 rand", 2'($urandom), 1'($urandom), 1'($urandom % 4 != 0), d,
          1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule